// File: doc/BRIEF.md
# Real-to-Absolute Address Swap with Page Key Marking

This block takes a real address that has already been through translation and turns it into an absolute address. It does this by exchanging two 8 KB windows. Real addresses in the lowest 8 KB go to the window that the per-CPU prefix register selects. Real addresses inside that prefix window go to the lowest 8 KB. Every other address passes through as it is. The absolute address is registered and appears one cycle after the request.

After remapping, the block keeps a small internal array that holds one two-bit usage key per 4 KB page. A request whose translation succeeded, and whose absolute address falls below the installed memory size, marks its page. The reference bit is set if the access permits reading, and the change bit is set if it permits writing. The update is a read-modify-write across two pipeline stages. A request to the same page in the very next cycle receives the value still in flight, so no marking is lost. Each key write is reported on a write port, two cycles after its request.

Top module: `prefix_key_unit`

## Requirements
- R1: A real address below 0x2000 becomes the aligned prefix with the real address's low 13 bits kept.
- R2: A real address whose bits above bit 12 equal those of the prefix becomes that address minus the aligned prefix. This check is made only after the R1 test fails.
- R3: Any real address that matches neither window appears unchanged on `abs_addr`.
- R4: Bits 12..0 of `prefix` have no effect on `abs_addr` or on the key written.
- R5: `abs_valid` is high exactly one cycle after `req_valid` is high. When `abs_valid` is high, `abs_addr` carries that request's result.
- R6: A key write (`key_wr_en`) happens two cycles after a request only if all three of these hold: `xlate_ok` was high, the absolute address was below `mem_limit`, and its page number was below `KEY_PAGES`. Otherwise no write happens.
- R7: `key_wr_page` equals the absolute address shifted right by 12.
- R8: `key_wr_val` is the page's previous key OR-ed with new bits. Bit 1 (reference) is OR-ed with `perm_rd` and bit 0 (change) is OR-ed with `perm_wr`. Bits are never cleared.
- R9: Updates to the same page in consecutive cycles accumulate, with each one seeing the bits written by the one before it.
- R10: While `rst_n` is low, `abs_valid` and `key_wr_en` are low and every key is zero. After reset, each page's first write shows only the new bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A translated address is presented |
| real_addr | input | ADDR_W | Real address from translation |
| prefix | input | ADDR_W | Per-CPU prefix; low 13 bits ignored |
| mem_limit | input | ADDR_W | Installed memory size in bytes |
| xlate_ok | input | 1 | Translation succeeded |
| perm_rd | input | 1 | Result permits reading |
| perm_wr | input | 1 | Result permits writing |
| abs_valid | output | 1 | Absolute address valid |
| abs_addr | output | ADDR_W | Absolute address |
| key_wr_en | output | 1 | A key was written this cycle |
| key_wr_page | output | log2(KEY_PAGES) | Page number written |
| key_wr_val | output | 2 | Key written: bit 1 reference, bit 0 change |

## Verification
A wrong internal key shows up on `key_wr_val` at the next write to that page. This happens two cycles after the request that touches the page, and it appears as a missing or extra bit compared with the accumulated OR of all earlier permissions for that page. A broken forward path affects only requests to the same page in consecutive cycles, so the stimulus deliberately strings such requests together. A wrong window decode appears on `abs_addr` one cycle after the request and also moves the key onto the wrong page. For that reason the corners at 0x1FFF, 0x2000, and the two ends of the prefix window are driven explicitly.

// File: rtl/pku_pkg.sv
package pku_pkg;
  typedef struct packed {
    logic ref_bit;
    logic chg_bit;
  } key_t;
endpackage

// File: rtl/pku_remap.sv
module pku_remap #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 13
) (
  input  logic [ADDR_W-1:0] real_addr,
  input  logic [ADDR_W-1:0] prefix,
  output logic [ADDR_W-1:0] abs_addr
);
  localparam int HI_W = ADDR_W - WIN_BITS;

  logic [HI_W-1:0] real_hi, pfx_hi;
  logic            in_low, in_pfx;

  always_comb begin
    real_hi = real_addr[ADDR_W-1:WIN_BITS];
    pfx_hi  = prefix[ADDR_W-1:WIN_BITS];
    in_low  = (real_hi == '0);
    in_pfx  = (real_hi == pfx_hi);
    if (in_low)      abs_addr = {pfx_hi, real_addr[WIN_BITS-1:0]};
    else if (in_pfx) abs_addr = {{HI_W{1'b0}}, real_addr[WIN_BITS-1:0]};
    else             abs_addr = real_addr;
  end
endmodule

// File: rtl/pku_keyram.sv
module pku_keyram
  import pku_pkg::*;
#(
  parameter int PAGES = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output key_t             rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  key_t             wr_data
);
  key_t mem_q [PAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGES; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem_q[rd_idx];
  end
endmodule

// File: rtl/prefix_key_unit.sv
module prefix_key_unit
  import pku_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS  = 13,
  parameter int KEY_PAGES = 64,
  localparam int IDX_W    = $clog2(KEY_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] real_addr,
  input  logic [ADDR_W-1:0] prefix,
  input  logic [ADDR_W-1:0] mem_limit,
  input  logic              xlate_ok,
  input  logic              perm_rd,
  input  logic              perm_wr,
  output logic              abs_valid,
  output logic [ADDR_W-1:0] abs_addr,
  output logic              key_wr_en,
  output logic [IDX_W-1:0]  key_wr_page,
  output logic [1:0]        key_wr_val
);
  localparam int PG_W = ADDR_W - PAGE_BITS;

  // stage 0: remap and decide
  logic [ADDR_W-1:0] abs_c;
  logic [PG_W-1:0]   page_c;
  logic [IDX_W-1:0]  idx_c;
  logic              upd_c, fwd_c;
  key_t              bits_c;

  pku_remap #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_remap (
    .real_addr (real_addr),
    .prefix    (prefix),
    .abs_addr  (abs_c)
  );

  // stage 1 state
  logic              s1_vld_q, s1_upd_q, s1_fwd_q;
  logic [ADDR_W-1:0] s1_abs_q;
  logic [IDX_W-1:0]  s1_idx_q;
  key_t              s1_bits_q, s1_fwd_val_q;
  key_t              ram_rd, old_key, new_key;

  // stage 2 state
  logic              s2_en_q;
  logic [IDX_W-1:0]  s2_idx_q;
  key_t              s2_val_q;

  always_comb begin
    page_c         = abs_c[ADDR_W-1:PAGE_BITS];
    idx_c          = page_c[IDX_W-1:0];
    upd_c          = req_valid && xlate_ok && (abs_c < mem_limit)
                     && (page_c < PG_W'(KEY_PAGES));
    bits_c.ref_bit = perm_rd;
    bits_c.chg_bit = perm_wr;
    // the RAM write of the current stage-1 op lands on the same edge as the read
    fwd_c          = upd_c && s1_upd_q && (s1_idx_q == idx_c);
    old_key        = s1_fwd_q ? s1_fwd_val_q : ram_rd;
    new_key        = old_key | s1_bits_q;
  end

  pku_keyram #(.PAGES(KEY_PAGES), .IDX_W(IDX_W)) u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (upd_c),
    .rd_idx  (idx_c),
    .rd_data (ram_rd),
    .wr_en   (s1_upd_q),
    .wr_idx  (s1_idx_q),
    .wr_data (new_key)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_upd_q <= 1'b0;
      s1_fwd_q <= 1'b0;
    end else begin
      s1_vld_q <= req_valid;
      s1_upd_q <= upd_c;
      s1_fwd_q <= fwd_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_abs_q     <= '0;
      s1_idx_q     <= '0;
      s1_bits_q    <= '0;
      s1_fwd_val_q <= '0;
    end else if (req_valid) begin
      s1_abs_q     <= abs_c;
      s1_idx_q     <= idx_c;
      s1_bits_q    <= bits_c;
      s1_fwd_val_q <= new_key;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  s2_en_q <= 1'b0;
    else         s2_en_q <= s1_upd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_idx_q <= '0;
      s2_val_q <= '0;
    end else if (s1_upd_q) begin
      s2_idx_q <= s1_idx_q;
      s2_val_q <= new_key;
    end
  end

  assign abs_valid   = s1_vld_q;
  assign abs_addr    = s1_abs_q;
  assign key_wr_en   = s2_en_q;
  assign key_wr_page = s2_idx_q;
  assign key_wr_val  = s2_val_q;
endmodule

// File: rtl/pku_check.sv
module pku_check #(
  parameter int ADDR_W    = 32,
  parameter int WIN_BITS  = 13,
  parameter int IDX_W     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] real_addr,
  input logic [ADDR_W-1:0] prefix,
  input logic              xlate_ok,
  input logic              perm_rd,
  input logic              perm_wr,
  input logic              abs_valid,
  input logic [ADDR_W-1:0] abs_addr,
  input logic              key_wr_en,
  input logic [1:0]        key_wr_val
);
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(1) << WIN_BITS;

  assert_abs_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> abs_valid);

  assert_abs_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !abs_valid);

  assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> abs_addr[WIN_BITS-1:0] == $past(real_addr[WIN_BITS-1:0]));

  assert_low_to_prefix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && real_addr < WIN)
      |=> abs_addr[ADDR_W-1:WIN_BITS] == $past(prefix[ADDR_W-1:WIN_BITS]));

  assert_no_write_on_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && xlate_ok) |=> ##1 !key_wr_en);

  assert_ref_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlate_ok && perm_rd) |=> ##1 (!key_wr_en || key_wr_val[1]));

  assert_chg_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xlate_ok && perm_wr) |=> ##1 (!key_wr_en || key_wr_val[0]));
endmodule

bind prefix_key_unit pku_check #(
  .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .IDX_W(IDX_W)
) u_pku_check (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .real_addr(real_addr),
  .prefix(prefix), .xlate_ok(xlate_ok), .perm_rd(perm_rd), .perm_wr(perm_wr),
  .abs_valid(abs_valid), .abs_addr(abs_addr), .key_wr_en(key_wr_en),
  .key_wr_val(key_wr_val)
);

// File: tb/test_prefix_key_unit.sv
module test_prefix_key_unit;
  localparam int AW = 32;
  localparam int NPG = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, xlate_ok, perm_rd, perm_wr;
  logic [AW-1:0] real_addr, prefix, mem_limit;
  logic          abs_valid, key_wr_en;
  logic [AW-1:0] abs_addr;
  logic [5:0]    key_wr_page;
  logic [1:0]    key_wr_val;

  always #2.5 clk = ~clk;

  prefix_key_unit i_prefix_key_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .real_addr(real_addr),
    .prefix(prefix), .mem_limit(mem_limit), .xlate_ok(xlate_ok),
    .perm_rd(perm_rd), .perm_wr(perm_wr), .abs_valid(abs_valid),
    .abs_addr(abs_addr), .key_wr_en(key_wr_en), .key_wr_page(key_wr_page),
    .key_wr_val(key_wr_val)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  logic [1:0] mk [NPG];
  bit         last_upd = 1'b0;
  int         last_idx = -1;

  bit         a_vq[$];
  logic [AW-1:0] a_aq[$];
  string      a_tq[$];
  bit         k_vq[$];
  int         k_pq[$];
  logic [1:0] k_dq[$];
  string      k_tq[$];

  function automatic logic [AW-1:0] ref_map(logic [AW-1:0] ra, logic [AW-1:0] pf);
    logic [AW-1:0] p = {pf[AW-1:13], 13'd0};
    if (ra < 32'h2000) return ra + p;
    if (ra >= p && {1'b0, ra} < {1'b0, p} + 33'h2000) return ra - p;
    return ra;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit e; logic [AW-1:0] a; string t; int pg; logic [1:0] d;
    e = a_vq.pop_front(); a = a_aq.pop_front(); t = a_tq.pop_front();
    chk(abs_valid == e, "R5", "abs_valid", AW'(abs_valid), AW'(e));
    if (e) chk(abs_addr == a, t, "abs_addr", abs_addr, a);
    e = k_vq.pop_front(); pg = k_pq.pop_front(); d = k_dq.pop_front(); t = k_tq.pop_front();
    chk(key_wr_en == e, "R6", "key_wr_en", AW'(key_wr_en), AW'(e));
    if (e) begin
      chk(int'(key_wr_page) == pg, "R7", "key_wr_page", AW'(key_wr_page), AW'(pg));
      chk(key_wr_val == d, t, "key_wr_val", AW'(key_wr_val), AW'(d));
    end
  endtask

  task automatic step(bit v, logic [AW-1:0] ra, logic [AW-1:0] pf, logic [AW-1:0] ml,
                      bit ok, bit rd, bit wr, string tag);
    logic [AW-1:0] ab; bit upd; int idx; logic [1:0] nv; string kt;
    @(negedge clk);
    compare();
    req_valid = v; real_addr = ra; prefix = pf; mem_limit = ml;
    xlate_ok = ok; perm_rd = rd; perm_wr = wr;
    ab  = ref_map(ra, pf);
    idx = int'(ab >> 12);
    upd = v && ok && (ab < ml) && (ab < AW'(NPG * 4096));
    a_vq.push_back(v); a_aq.push_back(ab); a_tq.push_back(tag);
    nv = 2'b00; kt = "R8";
    if (upd) begin
      if (last_upd && last_idx == idx) kt = "R9";
      nv = mk[idx] | {rd, wr};
      mk[idx] = nv;
    end
    k_vq.push_back(upd); k_pq.push_back(upd ? idx : 0); k_dq.push_back(nv); k_tq.push_back(kt);
    last_upd = upd; last_idx = idx;
  endtask

  task automatic idle();
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] P;
    for (int i = 0; i < NPG; i++) mk[i] = 2'b00;
    rst_n = 1'b0; req_valid = 0; real_addr = '0; prefix = '0; mem_limit = '0;
    xlate_ok = 0; perm_rd = 0; perm_wr = 0;
    repeat (3) @(negedge clk);
    // R10: outputs idle during reset
    chk(!abs_valid, "R10", "abs_valid in reset", AW'(abs_valid), 0);
    chk(!key_wr_en, "R10", "key_wr_en in reset", AW'(key_wr_en), 0);
    rst_n = 1'b1;
    a_vq.push_back(0); a_aq.push_back('0); a_tq.push_back("R5");
    repeat (2) begin
      k_vq.push_back(0); k_pq.push_back(0); k_dq.push_back(2'b00); k_tq.push_back("R10");
    end

    P = 32'h0000_A000;
    step(1, 32'h1234, P, 32'h40000, 1, 1, 0, "R1");  // low window -> prefix, R10 first key
    step(1, 32'hA010, P, 32'h40000, 1, 0, 1, "R2");  // prefix window -> low
    step(1, 32'h5000, P, 32'h40000, 1, 1, 1, "R3");  // pass-through
    step(1, 32'h0100, 32'hA1FF, 32'h40000, 1, 0, 1, "R4"); // prefix low bits ignored
    idle();
    // window edges (R1, R2, R3)
    step(1, 32'h1FFF, P, 32'h40000, 1, 0, 0, "R1");
    step(1, 32'h2000, P, 32'h40000, 1, 0, 0, "R3");
    step(1, 32'hBFFF, P, 32'h40000, 1, 0, 0, "R2");
    step(1, 32'hC000, P, 32'h40000, 1, 0, 0, "R3");
    step(1, 32'h9FFF, P, 32'h40000, 1, 0, 0, "R3");
    // R6: no update cases
    step(1, 32'h30000, P, 32'h20000, 1, 1, 1, "R3");
    step(1, 32'h6000, P, 32'h40000, 0, 1, 1, "R3");
    step(1, 32'h80000, P, 32'hFFFF_FFFF, 1, 1, 1, "R3");
    step(1, 32'h3FFFF, P, 32'h3F000, 1, 1, 1, "R3");
    // R9: consecutive same-page updates
    step(1, 32'h3000, P, 32'h40000, 1, 1, 0, "R3");
    step(1, 32'h3008, P, 32'h40000, 1, 0, 1, "R3");
    step(1, 32'h3FF0, P, 32'h40000, 1, 0, 0, "R3");
    step(1, 32'h7000, P, 32'h40000, 1, 0, 1, "R3");
    idle();
    step(1, 32'h7000, P, 32'h40000, 1, 1, 0, "R3");
    // R9 through the swap: low window hits prefix page, then direct prefix page
    step(1, 32'h0000, P, 32'h40000, 1, 0, 1, "R1");
    step(1, 32'hA000, 32'h0, 32'h40000, 1, 1, 0, "R3");
    idle(); idle();

    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] ra, pf, ml;
      int sel = $urandom_range(0, 9);
      pf = AW'($urandom_range(0, 31)) << 13;
      if (sel < 3)      ra = AW'($urandom_range(0, 32'h1FFF));
      else if (sel < 5) ra = pf + AW'($urandom_range(0, 32'h1FFF));
      else if (sel < 9) ra = AW'($urandom_range(0, 32'h4FFFF));
      else              ra = $urandom;
      case ($urandom_range(0, 2))
        0: ml = 32'h40000;
        1: ml = 32'h20000;
        default: ml = 32'hFFFF_FFFF;
      endcase
      step($urandom_range(0, 9) < 8, ra, pf, ml, $urandom_range(0, 9) < 9,
           1'($urandom), 1'($urandom), "R3");
    end
    idle(); idle(); idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule